// File: doc/BRIEF.md
# Serial Ones/Zeros Count Condition Detector

This block watches a single-bit serial line and takes one bit on every rising clock edge while reset is low. It flags the moment at which two conditions hold together. The first is that the count of 1s taken since reset is a multiple of three, and zero counts as a multiple. The second is that the count of 0s taken since reset is even and greater than zero. There is no framing and no handshake, so every clock edge outside reset consumes one bit.

Two outputs are provided. `moore_out` is registered and describes the bits already taken. `mealy_out` is combinational and gives, during the current cycle, the value that `moore_out` will take after the next edge if the bit now on `bit_in` is consumed.

A parameter selects between two equivalent implementations. The first is a pair of small interacting machines: a modulo-3 tracker for 1s and a three-class tracker for 0s (none, odd, even and nonzero), with their flags combined by an AND. The second is a single flattened machine with nine states. Any state encoding that the machine does not use leads back to the start state on the next edge.

Top module: `serial_cnt_cond_det`

## Requirements
- R1: While `rst` is high at a rising edge, the machine returns to the state "no 1s, no 0s", so `moore_out` is 0 in the cycle after that edge.
- R2: Each 1 consumed advances the ones count modulo 3. `moore_out` can only be 1 when the number of 1s consumed is 0, 3, 6 and so on.
- R3: With no 0 consumed yet, `moore_out` stays 0 whatever the number of 1s. After an odd number of 0s, `moore_out` is also 0.
- R4: After each rising edge with `rst` low, `moore_out` equals (ones mod 3 == 0) AND (zeros even AND zeros > 0), counted over all bits consumed since reset, including the bit taken at that edge.
- R5: When `rst` is low, `mealy_out` equals the value `moore_out` will show after the next rising edge, given the current value of `bit_in`.
- R6: A consumed 0 leaves the ones class unchanged, and a consumed 1 leaves the zeros class unchanged. For example, from a qualifying state, three 1s or two 0s lead back to `moore_out` = 1.
- R7: The split variant (`USE_FLAT`=0) and the flat nine-state variant (`USE_FLAT`=1) give identical `moore_out` and `mealy_out` on every cycle for the same input stream.
- R8: `moore_out` is 1 after two 0s and no 1s, and after three 1s and four 0s.
- R9: A reset applied in the middle of a stream discards all earlier bits, and counting restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one bit is consumed per edge |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial data bit |
| moore_out | output | 1 | Registered condition flag for the bits consumed so far |
| mealy_out | output | 1 | Combinational look-ahead of `moore_out` for the current `bit_in` |

## Verification
The checker enforces three relations on every cycle. The look-ahead output must match the next registered output. A qualifying state can never persist across a consumed bit. From a qualifying state, three 1s or two 0s must return to it. Only the bench's scenarios can show the absolute counting: that the zero-count class is kept apart from the nonzero even class, the two numeric examples, a restart after reset in mid-stream, and the cycle-exact agreement of both variants with a count-based model over long random streams of differing bit density.

// File: rtl/serial_det_pkg.sv
package serial_det_pkg;
  localparam int TRK_W  = 2;
  localparam int FLAT_W = 4;

  typedef enum logic [TRK_W-1:0] {
    ONES_R0 = 2'b00,
    ONES_R1 = 2'b01,
    ONES_R2 = 2'b10
  } ones_st_t;

  typedef enum logic [TRK_W-1:0] {
    ZC_NONE = 2'b00,
    ZC_ODD  = 2'b01,
    ZC_EVEN = 2'b10
  } zeros_st_t;

  // flat state = (ones residue, zero class)
  typedef enum logic [FLAT_W-1:0] {
    F_0N = 4'd0, F_0O = 4'd1, F_0E = 4'd2,
    F_1N = 4'd3, F_1O = 4'd4, F_1E = 4'd5,
    F_2N = 4'd6, F_2O = 4'd7, F_2E = 4'd8
  } flat_st_t;
endpackage

// File: rtl/ones_mod3_trk.sv
module ones_mod3_trk
  import serial_det_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  output logic flag_now,
  output logic flag_next
);
  ones_st_t st, nxt;

  always_comb begin
    case (st)
      ONES_R0: nxt = bit_in ? ONES_R1 : ONES_R0;
      ONES_R1: nxt = bit_in ? ONES_R2 : ONES_R1;
      ONES_R2: nxt = bit_in ? ONES_R0 : ONES_R2;
      default: nxt = ONES_R0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ONES_R0;
    else     st <= nxt;
  end

  assign flag_now  = (st == ONES_R0);
  assign flag_next = (nxt == ONES_R0);
endmodule

// File: rtl/zeros_class_trk.sv
module zeros_class_trk
  import serial_det_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  output logic flag_now,
  output logic flag_next
);
  zeros_st_t st, nxt;

  always_comb begin
    case (st)
      ZC_NONE: nxt = bit_in ? ZC_NONE : ZC_ODD;
      ZC_ODD:  nxt = bit_in ? ZC_ODD  : ZC_EVEN;
      ZC_EVEN: nxt = bit_in ? ZC_EVEN : ZC_ODD;
      default: nxt = ZC_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ZC_NONE;
    else     st <= nxt;
  end

  assign flag_now  = (st == ZC_EVEN);
  assign flag_next = (nxt == ZC_EVEN);
endmodule

// File: rtl/flat_prod_det.sv
module flat_prod_det
  import serial_det_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  output logic moore_out,
  output logic mealy_out
);
  flat_st_t st, nxt;

  always_comb begin
    case (st)
      F_0N:    nxt = bit_in ? F_1N : F_0O;
      F_0O:    nxt = bit_in ? F_1O : F_0E;
      F_0E:    nxt = bit_in ? F_1E : F_0O;
      F_1N:    nxt = bit_in ? F_2N : F_1O;
      F_1O:    nxt = bit_in ? F_2O : F_1E;
      F_1E:    nxt = bit_in ? F_2E : F_1O;
      F_2N:    nxt = bit_in ? F_0N : F_2O;
      F_2O:    nxt = bit_in ? F_0O : F_2E;
      F_2E:    nxt = bit_in ? F_0E : F_2O;
      default: nxt = F_0N;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= F_0N;
    else     st <= nxt;
  end

  assign moore_out = (st == F_0E);
  assign mealy_out = (nxt == F_0E);
endmodule

// File: rtl/serial_cnt_cond_det.sv
module serial_cnt_cond_det #(
  parameter bit USE_FLAT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  output logic moore_out,
  output logic mealy_out
);
  generate
    if (USE_FLAT) begin : g_flat
      flat_prod_det u_flat (
        .clk(clk), .rst(rst), .bit_in(bit_in),
        .moore_out(moore_out), .mealy_out(mealy_out)
      );
    end else begin : g_split
      logic ones_now, ones_next, zeros_now, zeros_next;
      ones_mod3_trk u_ones (
        .clk(clk), .rst(rst), .bit_in(bit_in),
        .flag_now(ones_now), .flag_next(ones_next)
      );
      zeros_class_trk u_zeros (
        .clk(clk), .rst(rst), .bit_in(bit_in),
        .flag_now(zeros_now), .flag_next(zeros_next)
      );
      assign moore_out = ones_now & zeros_now;
      assign mealy_out = ones_next & zeros_next;
    end
  endgenerate
endmodule

// File: rtl/serial_cnt_cond_chk.sv
module serial_cnt_cond_chk (
  input logic clk,
  input logic rst,
  input logic bit_in,
  input logic moore_out,
  input logic mealy_out
);
  // R5
  mealy_hi_chk: assert property (@(posedge clk) disable iff (rst)
    mealy_out |=> moore_out);
  // R5
  mealy_lo_chk: assert property (@(posedge clk) disable iff (rst)
    !mealy_out |=> !moore_out);
  // R4
  no_repeat_chk: assert property (@(posedge clk) disable iff (rst)
    moore_out |=> !moore_out);
  // R2
  three_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (moore_out && bit_in) ##1 bit_in ##1 bit_in |=> moore_out);
  // R6
  two_zeros_chk: assert property (@(posedge clk) disable iff (rst)
    (moore_out && !bit_in) ##1 !bit_in |=> moore_out);
endmodule

bind serial_cnt_cond_det serial_cnt_cond_chk chk_i (
  .clk(clk), .rst(rst), .bit_in(bit_in),
  .moore_out(moore_out), .mealy_out(mealy_out)
);

// File: tb/serial_cnt_cond_det_tb_top.sv
`timescale 1ns/1ps
module serial_cnt_cond_det_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic moore_s, mealy_s, moore_f, mealy_f;
  int checks = 0;
  int errors = 0;
  int ones_cnt = 0;
  int zeros_cnt = 0;

  always #5 clk = ~clk;

  serial_cnt_cond_det #(.USE_FLAT(1'b0)) dut_i (
    .clk(clk), .rst(rst), .bit_in(bit_in),
    .moore_out(moore_s), .mealy_out(mealy_s)
  );
  serial_cnt_cond_det #(.USE_FLAT(1'b1)) dut_flat_i (
    .clk(clk), .rst(rst), .bit_in(bit_in),
    .moore_out(moore_f), .mealy_out(mealy_f)
  );

  function automatic logic cond(input int o, input int z);
    return ((o % 3) == 0) && (z > 0) && ((z % 2) == 0);
  endfunction

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b (ones=%0d zeros=%0d)",
               req, act, exp, ones_cnt, zeros_cnt);
    end
  endtask

  // drive one bit, check look-ahead, then the registered result
  task automatic step(input logic b, input string req);
    logic e;
    bit_in = b;
    #1;
    e = cond(ones_cnt + (b ? 1 : 0), zeros_cnt + (b ? 0 : 1));
    chk(mealy_s, e, "R5 split mealy");
    chk(mealy_f, e, "R5 flat mealy");
    @(posedge clk);
    if (b) ones_cnt++; else zeros_cnt++;
    @(negedge clk);
    chk(moore_s, cond(ones_cnt, zeros_cnt), req);
    chk(moore_f, cond(ones_cnt, zeros_cnt), req);
    chk(moore_s ^ moore_f ^ mealy_s ^ mealy_f, 1'b0, "R7 variants equal");
  endtask

  task automatic do_reset(input string req);
    @(negedge clk);
    rst = 1'b1;
    bit_in = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    ones_cnt = 0;
    zeros_cnt = 0;
    chk(moore_s, 1'b0, req);
    chk(moore_f, 1'b0, req);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'h5eed_1234;
    do_reset("R1 reset state");
    step(1'b0, "R3 one zero");
    step(1'b0, "R8 two zeros no ones");
    step(1'b1, "R6 ones leave zeros");
    step(1'b1, "R2 two ones");
    step(1'b1, "R6 three ones return");
    step(1'b0, "R6 zeros leave ones");
    step(1'b0, "R8 three ones four zeros");
    do_reset("R9 mid-stream reset");
    for (int k = 0; k < 7; k++) step(1'b1, "R3 ones only");
    step(1'b0, "R3 odd zeros");
    step(1'b0, "R2 ones not multiple");
    for (int d = 1; d <= 3; d++) begin
      do_reset("R9 reset before stream");
      for (int k = 0; k < 3000; k++) begin
        logic b;
        b = (($urandom(seed) % 4) < d);
        seed = seed + 32'd7919;
        step(b, "R4 random stream");
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule